// File: doc/BRIEF.md
# Dual-Timebase Clock Source Selector

This block generates two free-running timebase counters for a timer coprocessor, entirely in the system clock domain. The first timebase advances on a prescaler strobe whose ratio is chosen by one control bit: a slow ratio of 32 system clocks or a fast ratio of 4. The second timebase is fed from one external pin. That pin either gates an internal divide-by-8 strobe, or acts as the counting clock after synchronization and digital filtering.

No divided or derived clock exists anywhere. Each divider produces a single-cycle enable strobe, and each counter advances by one on the clock edge that closes a strobe cycle. The strobes come out as ports so that later stages can follow the timebases. Changes to the select bits are applied only at the next terminal count of the divider they belong to. A period that is already running therefore always completes at its old length.

Top module: `dual_timebase`

## Requirements
- R1: While reset (rst_n low) is applied, both counts read 0 and both tick outputs are 0.
- R2: With fast_pre = 0, tb1_tick is high for one cycle out of every 32 system clock cycles.
- R3: With fast_pre = 1, tb1_tick is high for one cycle out of every 4 system clock cycles.
- R4: A change of fast_pre is applied only at the next prescaler terminal count. The running period keeps its old length, and the periods after it use the new one.
- R5: Each counter advances by exactly one on the clock edge that ends a cycle in which its tick is high. In all other cycles it holds. The counters are CNT_W bits wide (16 by default) and wrap from all-ones to 0.
- R6: With gate_mode = 1 and ext_pin held high, tb2_tick is high for one cycle out of every 8 system clock cycles.
- R7: With gate_mode = 1 and ext_pin held low, tb2_tick stays 0 and tb2_count holds.
- R8: With gate_mode = 0, each accepted rising edge of ext_pin produces exactly one single-cycle tb2_tick. If ext_pin rises just after a clock edge, the tick is high during the cycle that follows the fourth rising clock edge after that change.
- R9: With gate_mode = 0, a level on ext_pin is accepted only after 3 consecutive synchronized samples agree. A high pulse or a low glitch lasting 2 cycles causes no count.
- R10: tb2_count wraps from all-ones to 0 on a tick.
- R11: A change of gate_mode is applied only at the next terminal count of the divide-by-8 strobe. A gated period already in progress still delivers its tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External pin for the second timebase, asynchronous |
| gate_mode | input | 1 | 1: pin gates the divide-by-8 strobe; 0: filtered pin edges clock the counter |
| fast_pre | input | 1 | Prescaler select for the first timebase: 0 divides by 32, 1 divides by 4 |
| tb1_count | output | CNT_W | First timebase value |
| tb1_tick | output | 1 | Increment strobe of the first timebase |
| tb2_count | output | CNT_W | Second timebase value |
| tb2_tick | output | 1 | Increment strobe of the second timebase |

## Verification
The hardest situations to reach are the select changes in the middle of a period. For these the bench waits for a tick and then moves a select bit a few cycles later, so the old ratio must still finish one full period before the new one applies. For the mode bit, the result is one final gated tick followed by silence, because the pin is held steady at a high level. The filter boundary is reached by driving pulses exactly 2 and 3 cycles wide, each placed just after a clock edge. A narrow-width second instance brings both counters to their wrap point within the run.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
   typedef enum logic {
      TB2_SRC_PIN_CLK = 1'b0,
      TB2_SRC_GATED   = 1'b1
   } tb2_src_e;
endpackage

// File: rtl/dtb_strobe_div.sv
module dtb_strobe_div #(
   parameter int DIV_LO = 32,
   parameter int DIV_HI = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_hi,
   output logic stb
);
   localparam int DMAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
   localparam int CW   = $clog2(DMAX);

   if (DIV_LO < 2 || DIV_HI < 2) begin : g_bad_ratio
      $error("dtb_strobe_div: both ratios must be at least 2");
   end

   logic [CW-1:0] cnt;

   if (DIV_LO == DIV_HI) begin : g_fixed
      logic unused_sel;
      assign unused_sel = sel_hi;
      assign stb = (cnt == CW'(DIV_LO - 1));
      always_ff @(posedge clk) begin
         if (!rst_n)   cnt <= '0;
         else if (stb) cnt <= '0;
         else          cnt <= cnt + 1'b1;
      end
   end else begin : g_dual
      logic          act_hi;
      logic [CW-1:0] term;
      assign term = act_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
      assign stb  = (cnt == term);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt    <= '0;
            act_hi <= 1'b0;
         end else if (stb) begin
            cnt    <= '0;
            act_hi <= sel_hi;
         end else begin
            cnt    <= cnt + 1'b1;
         end
      end
      AST_SEL_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
         (act_hi != $past(act_hi)) |-> $past(stb)); // R4
   end

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> !stb); // R2
endmodule

// File: rtl/dtb_pin_filter.sv
module dtb_pin_filter #(
   parameter int SYNC_N = 2,
   parameter int FILT_N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic pin_sync,
   output logic rise
);
   if (SYNC_N < 2) begin : g_bad_sync
      $error("dtb_pin_filter: SYNC_N must be at least 2");
   end
   if (FILT_N < 3) begin : g_bad_filt
      $error("dtb_pin_filter: FILT_N must be at least 3");
   end

   logic [SYNC_N-1:0] chain;
   logic [FILT_N-2:0] hist;
   logic              filt;
   logic              all_hi;
   logic              all_lo;

   assign pin_sync = chain[SYNC_N-1];
   assign all_hi   = pin_sync & (&hist);
   assign all_lo   = ~pin_sync & ~(|hist);
   assign rise     = all_hi & ~filt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
         hist  <= '0;
         filt  <= 1'b0;
      end else begin
         chain <= {chain[SYNC_N-2:0], pin};
         hist  <= {hist[FILT_N-3:0], pin_sync};
         if (all_hi)      filt <= 1'b1;
         else if (all_lo) filt <= 1'b0;
      end
   end

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R8
   AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> $past(pin_sync)); // R9
endmodule

// File: rtl/dtb_counter.sv
module dtb_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   if (W < 2) begin : g_bad_width
      $error("dtb_counter: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> (count == W'($past(count) + 1'b1))); // R5
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count)); // R5
endmodule

// File: rtl/dual_timebase.sv
module dual_timebase
   import dtb_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PRE_SLOW = 32,
   parameter int PRE_FAST = 4,
   parameter int GATE_DIV = 8,
   parameter int SYNC_N   = 2,
   parameter int FILT_N   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_pin,
   input  logic             gate_mode,
   input  logic             fast_pre,
   output logic [CNT_W-1:0] tb1_count,
   output logic             tb1_tick,
   output logic [CNT_W-1:0] tb2_count,
   output logic             tb2_tick
);
   tb2_src_e mode_q;
   logic     g_stb;
   logic     pin_sync;
   logic     pin_rise;

   dtb_strobe_div #(.DIV_LO(PRE_SLOW), .DIV_HI(PRE_FAST)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel_hi(fast_pre), .stb(tb1_tick));

   dtb_strobe_div #(.DIV_LO(GATE_DIV), .DIV_HI(GATE_DIV)) u_gdiv (
      .clk(clk), .rst_n(rst_n), .sel_hi(1'b0), .stb(g_stb));

   dtb_pin_filter #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin),
      .pin_sync(pin_sync), .rise(pin_rise));

   always_ff @(posedge clk) begin
      if (!rst_n)     mode_q <= TB2_SRC_PIN_CLK;
      else if (g_stb) mode_q <= tb2_src_e'(gate_mode);
   end

   assign tb2_tick = (mode_q == TB2_SRC_GATED) ? (g_stb & pin_sync) : pin_rise;

   dtb_counter #(.W(CNT_W)) u_cnt1 (
      .clk(clk), .rst_n(rst_n), .inc(tb1_tick), .count(tb1_count));

   dtb_counter #(.W(CNT_W)) u_cnt2 (
      .clk(clk), .rst_n(rst_n), .inc(tb2_tick), .count(tb2_count));

   AST_MODE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> $past(g_stb)); // R11
   AST_GATED_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TB2_SRC_GATED && tb2_tick) |-> $past(ext_pin, 2)); // R7
endmodule

// File: tb/dual_timebase_test.sv
`timescale 1ns/1ps
module dual_timebase_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_pin = 1'b1;
   logic        gate_mode = 1'b1;
   logic        fast_pre = 1'b0;
   logic [15:0] tb1_count, tb2_count;
   logic        tb1_tick, tb2_tick;
   logic [7:0]  s1_count, s2_count;
   logic        s1_tick, s2_tick;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last1 = 0, last2 = 0, gexp = 0;
   int    q1[$], q2[$];
   string q1r[$], q2r[$];
   string gr;

   always #2.5 clk = ~clk;

   dual_timebase uut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .gate_mode(gate_mode),
      .fast_pre(fast_pre), .tb1_count(tb1_count), .tb1_tick(tb1_tick),
      .tb2_count(tb2_count), .tb2_tick(tb2_tick));

   dual_timebase #(.CNT_W(8)) uut_w8 (
      .clk(clk), .rst_n(rst_n), .ext_pin(1'b1), .gate_mode(1'b1),
      .fast_pre(1'b1), .tb1_count(s1_count), .tb1_tick(s1_tick),
      .tb2_count(s2_count), .tb2_tick(s2_tick));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected tick gaps and compares with observed gaps
   always @(negedge clk) begin
      if (rst_n && tb1_tick) begin
         if (q1.size() > 0) begin
            gexp = q1.pop_front();
            gr   = q1r.pop_front();
            chk((cyc - last1) == gexp, gr, cyc - last1, gexp);
         end
         last1 = cyc;
      end
      if (rst_n && tb2_tick) begin
         if (q2.size() > 0) begin
            gexp = q2.pop_front();
            gr   = q2r.pop_front();
            chk((cyc - last2) == gexp, gr, cyc - last2, gexp);
         end
         last2 = cyc;
      end
   end

   task automatic push1(input int g, input string r);
      q1.push_back(g); q1r.push_back(r);
   endtask
   task automatic push2(input int g, input string r);
      q2.push_back(g); q2r.push_back(r);
   endtask
   task automatic wait_t1();
      do @(negedge clk); while (!tb1_tick);
   endtask
   task automatic wait_t2();
      do @(negedge clk); while (!tb2_tick);
   endtask
   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [15:0] c;
      bit seen;
      cycles(5);
      // R1: reset state
      chk(tb1_count == 0, "R1 tb1_count", tb1_count, 0);
      chk(tb2_count == 0, "R1 tb2_count", tb2_count, 0);
      chk(tb1_tick == 0 && tb2_tick == 0, "R1 ticks", {tb1_tick, tb2_tick}, 0);
      rst_n = 1'b1;

      // R2 slow prescaler, R5 step
      wait_t1();
      c = tb1_count;
      @(posedge clk);
      push1(32, "R2 slow gap"); push1(32, "R2 slow gap");
      @(negedge clk);
      chk(tb1_count == c + 16'd1, "R5 tb1 step", tb1_count, c + 16'd1);
      wait_t1(); wait_t1();

      // R6 gated period with pin high
      wait_t2();
      @(posedge clk);
      push2(8, "R6 gated gap"); push2(8, "R6 gated gap"); push2(8, "R6 gated gap");
      wait_t2(); wait_t2(); wait_t2();

      // R4 select change mid-period, then R3 fast period
      wait_t1();
      @(posedge clk);
      push1(32, "R4 old ratio completes");
      push1(4, "R3 fast gap"); push1(4, "R3 fast gap"); push1(4, "R3 fast gap");
      cycles(3);
      fast_pre = 1'b1;
      wait_t1(); wait_t1(); wait_t1(); wait_t1();

      // R7 gate low blocks counting
      ext_pin = 1'b0;
      cycles(4);
      c = tb2_count;
      seen = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (tb2_tick) seen = 1;
      end
      chk(!seen, "R7 no tick while gated low", seen, 0);
      chk(tb2_count == c, "R7 count holds", tb2_count, c);
      ext_pin = 1'b1;
      cycles(10);

      // R11 mode change takes effect at next divide-by-8 terminal
      wait_t2();
      @(posedge clk);
      push2(8, "R11 gated period completes");
      cycles(2);
      gate_mode = 1'b0;
      wait_t2();
      c = tb2_count;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (tb2_tick) seen = 1;
      end
      chk(!seen, "R11 no tick after switch", seen, 0);
      chk(tb2_count == c + 16'd1, "R11 count", tb2_count, c + 16'd1);

      // R8 clock mode: latency and single step
      ext_pin = 1'b0;
      cycles(10);
      c = tb2_count;
      ext_pin = 1'b1;
      seen = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (tb2_tick) seen = 1;
      end
      chk(!seen, "R8 no early tick", seen, 0);
      @(negedge clk);
      chk(tb2_tick == 1'b1, "R8 tick after 4th edge", tb2_tick, 1);
      @(negedge clk);
      chk(tb2_tick == 1'b0, "R8 tick single cycle", tb2_tick, 0);
      chk(tb2_count == c + 16'd1, "R8 one step", tb2_count, c + 16'd1);
      cycles(10);
      chk(tb2_count == c + 16'd1, "R8 steady high no count", tb2_count, c + 16'd1);
      ext_pin = 1'b0;
      cycles(10);

      // R8 three 3-cycle pulses
      c = tb2_count;
      for (int i = 0; i < 3; i++) begin
         ext_pin = 1'b1; cycles(3);
         ext_pin = 1'b0; cycles(4);
      end
      cycles(8);
      chk(tb2_count == c + 16'd3, "R8 three pulses", tb2_count, c + 16'd3);

      // R9 2-cycle pulses rejected
      c = tb2_count;
      for (int i = 0; i < 3; i++) begin
         ext_pin = 1'b1; cycles(2);
         ext_pin = 1'b0; cycles(5);
      end
      cycles(8);
      chk(tb2_count == c, "R9 short pulses ignored", tb2_count, c);

      // R9 2-cycle low glitch inside a high level: single count
      ext_pin = 1'b1; cycles(10);
      ext_pin = 1'b0; cycles(2);
      ext_pin = 1'b1; cycles(10);
      chk(tb2_count == c + 16'd1, "R9 low glitch ignored", tb2_count, c + 16'd1);

      // R5 / R10 wrap on narrow instance
      do @(negedge clk); while (!(s1_tick && s1_count == 8'hFF));
      @(negedge clk);
      chk(s1_count == 8'h00, "R5 tb1 wrap", s1_count, 0);
      do @(negedge clk); while (!(s2_tick && s2_count == 8'hFF));
      @(negedge clk);
      chk(s2_count == 8'h00, "R10 tb2 wrap", s2_count, 0);

      chk(q1.size() == 0 && q2.size() == 0, "R2 scoreboard drained", q1.size() + q2.size(), 0);
      finish_run();
   end
endmodule